// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Processor Bus Port

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter that a processor addresses as a plain memory or I/O location. The processor starts a conversion with a write strobe and collects the result with a read strobe. Both strobes are qualified by an active-low chip select. Between start and finish, the controller presents a trial code to an external DAC once per trial and samples a single comparator bit. It resolves the code from the most significant bit down to the least.

The write strobe, read strobe and chip select arrive asynchronously and are synchronised to the free-running converter clock. Holding chip select and write low keeps the converter in reset for as long as the pulse lasts. The conversion begins when the write strobe returns high. Trials only start on a boundary of the internal 8-clock trial phase, so the start latency varies by up to eight clocks.

At completion the code moves into an output latch and an active-low interrupt is raised. A new write or a qualified read clears the interrupt. The output latch reaches the bus only while chip select and read are both low; the pad ring turns the enable into a three-state driver. Wiring the interrupt back to the write input, with chip select held low, makes the converter restart after every completion.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `dac_code` is 0x00, `dout_en` is 0, and a read returns 0x00.
- R2: While the synchronised chip select and write are both low, no trial runs: `dac_code` stays 0x00 and `intr_n` stays 1, however long the pulse lasts.
- R3: A conversion starts on the rising edge of `wr_n` with chip select low. `intr_n` falls between 68 and 75 clock edges after that rising edge.
- R4: Trials run most significant bit first, one bit per 8 clocks. The first trial code is 0x80. The next trial sets the next lower bit, after keeping or clearing the bit just tried.
- R5: `cmp_keep` = 1 means the positive input is at or above the trial level. The bit under trial is then kept; otherwise it is cleared. With an ideal comparator the finished code equals the input value.
- R6: If `cmp_keep` is 0 on every trial, the finished code is 0x00.
- R7: A read with chip select low (both synchronised) sets `intr_n` back to 1 within 3 clock edges.
- R8: A new write with chip select low sets `intr_n` back to 1 within 3 clock edges of the write going low.
- R9: `dout_en` is 1 exactly while `cs_n` and `rd_n` are both low. `dout` then shows the last completed code.
- R10: With `intr_n` fed back to `wr_n` and chip select held low, conversions repeat without further stimulus. Each one completes and tracks the current input.
- R11: A start issued during a conversion aborts it. The output latch keeps its previous value until a later conversion completes.
- R12: A write pulse with `cs_n` high starts nothing and leaves `intr_n` and the output latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| wr_n | input | 1 | Active-low write strobe; the rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe |
| cmp_keep | input | 1 | Comparator result: 1 keeps the bit under trial |
| dac_code | output | 8 | Trial code to the external DAC |
| dout | output | 8 | Output latch contents for the data bus |
| dout_en | output | 1 | Bus drive enable for the three-state pads |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
A wrong state in the trial shift register or in the bit-clear logic shows up at `dac_code` within 8 clocks: the next trial code differs from the halving sequence the bench predicts from the input value. A lost start or a misaligned phase moves the interrupt out of its 68-to-75-clock window, and the bench detects that on the first conversion. An output latch written at the wrong time shows up at the next qualified read. This is most visible after an aborted conversion, where the old code must still be present.

// File: rtl/sar_bus_ctrl_pkg.sv
// Shared constants for the converter controller.
// Assumes: trial code width and phase width are set here once for the block.
package sar_bus_ctrl_pkg;
    localparam int CODE_W  = 8;   // bits resolved per conversion
    localparam int PHASE_W = 3;   // 2**PHASE_W clocks per bit trial
    localparam int SYNC_N  = 2;   // synchroniser depth for the bus strobes
endpackage

// File: rtl/sar_strobe_sync.sv
// Multi-stage synchroniser for asynchronous active-low bus strobes.
// Assumes: each bit is an independent level; RST_VAL is the idle level.
module sar_strobe_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) st[0] <= RST_VAL;
                else        st[0] <= d;
            end
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) st[i] <= RST_VAL;
                else        st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sar_strobe_decode.sv
// Turns synchronised strobes into hold, start and read-access events.
// Assumes: inputs are already synchronised and active-low.
module sar_strobe_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_n,
    input  logic wr_s_n,
    input  logic rd_s_n,
    output logic hold,
    output logic start_evt,
    output logic rd_acc
);
    logic hold_q;

    assign hold   = !cs_s_n && !wr_s_n;
    assign rd_acc = !cs_s_n && !rd_s_n;
    // the start is the end of a hold interval
    assign start_evt = hold_q && !hold;

    // remember last cycle's hold to find its release
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold;
    end
endmodule

// File: rtl/sar_engine.sv
// Successive-approximation sequencer: phase counter, start flop, trial
// shift register and approximation register.
// Assumes: cmp_keep is stable by the last clock of each trial phase.
module sar_engine #(
    parameter int CODE_W = 8,
    parameter int PHASE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              start_evt,
    input  logic              cmp_keep,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] ring,
    output logic              done,
    output logic [CODE_W-1:0] result
);
    localparam logic [PHASE_W-1:0] PH_LAST = '1;
    localparam logic [CODE_W-1:0]  MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

    logic [PHASE_W-1:0] ph;
    logic               pend;
    logic               busy;
    logic [CODE_W-1:0]  sar;
    logic               trial_end;
    logic [CODE_W-1:0]  decided;

    assign trial_end = busy && (ph == PH_LAST);
    // clear the bit under trial when the comparator rejects it
    assign decided   = cmp_keep ? sar : (sar & ~ring);
    assign done      = trial_end && ring[0];
    assign result    = decided;
    assign dac_code  = sar;

    // free-running trial phase, never realigned to the start
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + 1'b1;
    end

    // start flop, trial shift register and approximation register
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pend <= 1'b0;
            busy <= 1'b0;
            ring <= '0;
            sar  <= '0;
        end else if (start_evt) begin
            pend <= 1'b1;
        end else if (pend && ph == PH_LAST) begin
            pend <= 1'b0;
            busy <= 1'b1;
            ring <= MSB_ONE;
            sar  <= MSB_ONE;
        end else if (trial_end) begin
            if (ring[0]) begin
                busy <= 1'b0;
                ring <= '0;
                sar  <= decided;
            end else begin
                ring <= ring >> 1;
                sar  <= decided | (ring >> 1);
            end
        end
    end
endmodule

// File: rtl/sar_result_latch.sv
// Output latch and interrupt flop for the converter bus port.
// Assumes: done is a one-cycle pulse; hold and rd_acc are synchronised.
module sar_result_latch #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [CODE_W-1:0] result,
    input  logic              hold,
    input  logic              rd_acc,
    output logic [CODE_W-1:0] q,
    output logic              intr_n
);
    // capture the finished code only on completion
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (done) q <= result;
    end

    // raise on completion, clear on a new write or a read
    always_ff @(posedge clk) begin
        if (!rst_n)                intr_n <= 1'b1;
        else if (done)             intr_n <= 1'b0;
        else if (hold || rd_acc)   intr_n <= 1'b1;
    end
endmodule

// File: rtl/sar_bus_ctrl.sv
// Top level of the successive-approximation controller with processor bus port.
// Assumes: the pad ring builds the three-state driver from dout/dout_en;
// the bus strobes are asynchronous to clk.
module sar_bus_ctrl
    import sar_bus_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_keep,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] dout,
    output logic              dout_en,
    output logic              intr_n
);
    logic [2:0]        strobe_s;
    logic              hold_w;
    logic              start_w;
    logic              rd_acc_w;
    logic              done_w;
    logic [CODE_W-1:0] ring_w;
    logic [CODE_W-1:0] result_w;

    sar_strobe_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, wr_n, rd_n}), .q(strobe_s)
    );

    sar_strobe_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .cs_s_n(strobe_s[2]), .wr_s_n(strobe_s[1]), .rd_s_n(strobe_s[0]),
        .hold(hold_w), .start_evt(start_w), .rd_acc(rd_acc_w)
    );

    sar_engine #(.CODE_W(CODE_W), .PHASE_W(PHASE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .hold(hold_w), .start_evt(start_w),
        .cmp_keep(cmp_keep), .dac_code(dac_code), .ring(ring_w),
        .done(done_w), .result(result_w)
    );

    sar_result_latch #(.CODE_W(CODE_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .done(done_w), .result(result_w),
        .hold(hold_w), .rd_acc(rd_acc_w), .q(dout), .intr_n(intr_n)
    );

    // bus drive follows the raw strobes, as the pad enable is asynchronous
    assign dout_en = !cs_n && !rd_n;
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
// Property checker for sar_bus_ctrl, attached by bind.
// Assumes: signal names of the top-level instance as connected below.
module sar_bus_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              rd_acc,
    input logic              done,
    input logic [CODE_W-1:0] result,
    input logic [CODE_W-1:0] ring,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] dout,
    input logic              intr_n
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (dac_code == '0) && intr_n); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !done) |=> intr_n); // R7

    AST_DONE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !intr_n && (dout == $past(result))); // R3

    AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(dout)); // R11

    AST_ONE_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring)); // R4
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.CODE_W(sar_bus_ctrl_pkg::CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold(hold_w), .rd_acc(rd_acc_w),
    .done(done_w), .result(result_w), .ring(ring_w),
    .dac_code(dac_code), .dout(dout), .intr_n(intr_n)
);

// File: tb/sar_bus_ctrl_test.sv
module sar_bus_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_drv = 1'b1;
    logic       rd_n = 1'b1;
    logic       freerun = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       force_low = 1'b0;
    logic       wr_pin;
    logic       cmp_keep;
    logic [7:0] dac_code;
    logic [7:0] dout;
    logic       dout_en;
    logic       intr_n;
    int         n_chk = 0;
    int         n_fail = 0;

    always #10 clk = ~clk;

    // ideal comparator model; force_low models an input below every level
    assign cmp_keep = force_low ? 1'b0 : (vin >= dac_code);
    assign wr_pin   = freerun ? (intr_n & wr_drv) : wr_drv;

    sar_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_pin), .rd_n(rd_n),
        .cmp_keep(cmp_keep), .dac_code(dac_code), .dout(dout),
        .dout_en(dout_en), .intr_n(intr_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_conv(input int low_cycles);
        @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
        repeat (low_cycles) @(negedge clk);
        wr_drv = 1'b1; cs_n = 1'b1;
    endtask

    // counts edges from the write release until intr_n is seen low
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (cyc < 300) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (!intr_n) break;
        end
    endtask

    task automatic bus_read(output logic [7:0] v, output logic en);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        #1; v = dout; en = dout_en;
        repeat (4) @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v; logic en;
        check("R1 intr_n", int'(intr_n), 1);
        check("R1 dac_code", int'(dac_code), 0);
        check("R1 dout_en", int'(dout_en), 0);
        bus_read(v, en);
        check("R1 read value", int'(v), 0);
    endtask

    task automatic t_convert(input logic [7:0] val, input string req);
        int c; logic [7:0] v; logic en;
        vin = val;
        start_conv(3);
        wait_done(c);
        check("R3 latency in 68..75", int'(c >= 68 && c <= 75), 1);
        bus_read(v, en);
        check(req, int'(v), int'(val));
        check("R9 dout_en during read", int'(en), 1);
        check("R9 dout_en after read", int'(dout_en), 0);
        check("R7 intr_n cleared by read", int'(intr_n), 1);
    endtask

    task automatic t_msb_order();
        int c;
        vin = 8'h30;
        start_conv(3);
        c = 0;
        while (dac_code == 8'h00 && c < 40) begin @(negedge clk); c++; end
        check("R4 first trial", int'(dac_code), 8'h80);
        repeat (8) @(negedge clk);
        check("R4 second trial", int'(dac_code), 8'h40);
        repeat (8) @(negedge clk);
        check("R4 third trial", int'(dac_code), 8'h20);
        repeat (8) @(negedge clk);
        check("R4 fourth trial", int'(dac_code), 8'h30);
        wait_done(c);
    endtask

    task automatic t_write_clears();
        @(negedge clk);
        check("R8 intr low before write", int'(intr_n), 0);
        cs_n = 1'b0; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 intr cleared by write", int'(intr_n), 1);
        wr_drv = 1'b1; cs_n = 1'b1;
        repeat (90) @(negedge clk);
    endtask

    task automatic t_long_hold();
        logic [7:0] v; logic en; int c; int bad;
        vin = 8'h5A; bad = 0;
        @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (dac_code != 8'h00 || !intr_n) bad++;
        end
        check("R2 no trial during hold", bad, 0);
        wr_drv = 1'b1; cs_n = 1'b1;
        wait_done(c);
        check("R3 latency after long hold", int'(c >= 68 && c <= 75), 1);
        bus_read(v, en);
        check("R2 result after long hold", int'(v), 8'h5A);
    endtask

    task automatic t_abort();
        logic [7:0] v; logic en; int c;
        vin = 8'h11;
        start_conv(3);
        repeat (30) @(negedge clk);
        cs_n = 1'b0; wr_drv = 1'b0;
        vin = 8'h3C;
        repeat (5) @(negedge clk);
        rd_n = 1'b0; #1;
        check("R11 latch kept after abort", int'(dout), 8'hA5);
        @(negedge clk); rd_n = 1'b1;
        wr_drv = 1'b1; cs_n = 1'b1;
        wait_done(c);
        check("R11 restart latency", int'(c >= 68 && c <= 75), 1);
        bus_read(v, en);
        check("R11 new result", int'(v), 8'h3C);
    endtask

    task automatic t_no_cs();
        logic [7:0] v; logic en; int bad;
        bad = 0;
        @(negedge clk); wr_drv = 1'b0;
        repeat (5) @(negedge clk);
        wr_drv = 1'b1;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (!intr_n || dac_code != 8'h3C) bad++;
        end
        check("R12 no start without select", bad, 0);
        bus_read(v, en);
        check("R12 latch unchanged", int'(v), 8'h3C);
    endtask

    task automatic t_freerun();
        logic [7:0] v; logic en; int falls; logic prev;
        vin = 8'h21;
        @(negedge clk); cs_n = 1'b0; freerun = 1'b1; wr_drv = 1'b0;
        repeat (3) @(negedge clk);
        wr_drv = 1'b1;
        falls = 0; prev = intr_n;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (prev && !intr_n) falls++;
            prev = intr_n;
            if (i == 150) vin = 8'h77;
        end
        check("R10 repeated conversions", int'(falls >= 4 && falls <= 6), 1);
        freerun = 1'b0; cs_n = 1'b1;
        repeat (100) @(negedge clk);
        bus_read(v, en);
        check("R10 tracks input", int'(v), 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_convert(8'hA5, "R5 code A5");
        t_convert(8'hFF, "R5 code FF");
        t_convert(8'h01, "R5 code 01");
        t_convert(8'h80, "R5 code 80");
        force_low = 1'b1;
        t_convert(8'h00, "R6 all rejected gives 00");
        force_low = 1'b0;
        t_msb_order();
        t_write_clears();
        t_long_hold();
        t_convert(8'hA5, "R5 code A5 again");
        t_abort();
        t_no_cs();
        t_freerun();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule